// File: doc/BRIEF.md
# LIN Master Frame Transmitter

This block drives the master side of a LIN frame onto a single-wire bus. Software loads a 6-bit identifier, a data length, a direction bit, a checksum-type bit and up to eight data bytes, then pulses a header request. The block captures the configuration at that moment. It sends a break, the sync character and the protected identifier. When the master publishes the response, it goes on to send the data bytes and a checksum without any further action from software.

Responses longer than the eight-byte buffer are sent in chunks. After every eight bytes, while bytes remain, the block raises a buffer-empty flag and holds the bus recessive. It resumes when software has written the next chunk and pulsed the flag clear. Each transmitted bit is read back from the bus at mid-bit. A mismatch aborts the frame and raises a bit-error flag. Bit timing is derived from an external baud tick, with `OVS` ticks per bit.

Top module: `linMasterTx`

## Requirements
- R1: After reset `txOut` is 1, `busy` is 0 and all four flags are 0. Whenever `busy` is 0, `txOut` is 1.
- R2: An accepted request starts with a break of 13 bit times at 0, followed by one recessive delimiter bit.
- R3: The sync character 0x55 follows the break. Every character is sent as one start bit (0), eight data bits LSB first, and one stop bit (1).
- R4: The third character is the protected identifier. Bits 5:0 are the ID, bit 6 is ID0^ID1^ID2^ID4, and bit 7 is the inverse of ID1^ID3^ID4^ID5.
- R5: When `cfgPublish` is 1, the block sends cfgDfl+1 data bytes and then the checksum. Data byte k of each chunk is taken from `bufData[8k+7:8k]`.
- R6: When `cfgEnhanced` is 0, the checksum is the inverted 8-bit end-around-carry sum of the data bytes.
- R7: When `cfgEnhanced` is 1, the checksum sum also includes the protected identifier.
- R8: `doneFlag` rises only when a checksum has been sent with no error. All flags clear when the next request is accepted.
- R9: When `cfgPublish` is 0, the frame ends after the identifier. `hdrDoneFlag` rises, `doneFlag` stays 0 and `busy` falls.
- R10: When more than 8 bytes are configured, `bufEmptyFlag` rises after each group of 8 bytes that still has bytes after it. No flag is raised after the final group. While the flag is set the bus stays recessive. A `bufEmptyClr` pulse resumes the frame from `bufData` byte 0.
- R11: If a read-back bit differs from the sent bit, the frame stops, `bitErrFlag` rises, `doneFlag` stays 0 and the bus returns to recessive.
- R12: `busy` goes high in the cycle after an accepted request and stays high until the frame ends. A request while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| baudTick | input | 1 | Oversample tick, OVS per bit |
| hdrReq | input | 1 | Header request strobe |
| cfgId | input | 6 | Frame identifier |
| cfgDfl | input | DFL_W | Data bytes minus one |
| cfgPublish | input | 1 | 1: master sends the response |
| cfgEnhanced | input | 1 | 1: enhanced checksum |
| bufData | input | 64 | Eight-byte message buffer |
| bufEmptyClr | input | 1 | Buffer refilled strobe |
| busIn | input | 1 | Bus read-back |
| txOut | output | 1 | Bus transmit |
| busy | output | 1 | Frame in progress |
| doneFlag | output | 1 | Response sent without error |
| hdrDoneFlag | output | 1 | Header-only frame finished |
| bitErrFlag | output | 1 | Read-back mismatch |
| bufEmptyFlag | output | 1 | Buffer needs a refill |

## Verification
The bench decodes every character from `txOut` and compares it with a stream it builds itself, so a wrong parity bit, a bit-order error or a checksum missing the end-around carry or the identifier shows up as a mismatched byte. Frames of exactly eight bytes and of twenty bytes test the refill boundary: an off-by-one would raise a spurious flag before the checksum, or resume from the wrong buffer byte. A request issued mid-frame with a changed configuration would corrupt the stream if it were accepted. Forcing the delimiter low must stop the frame with no further characters, and a block that ignored the read-back would send the sync byte anyway.

// File: rtl/linTxPkg.sv
package linTxPkg;

  localparam int IDX_W     = 3;
  localparam int BUF_BYTES = 1 << IDX_W;

  typedef enum logic [1:0] {SEL_SYNC, SEL_PID, SEL_DATA, SEL_CSUM} charSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BREAK, ST_SYNC, ST_PID, ST_DATA, ST_WAIT, ST_CSUM
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadBreak;
    logic             loadChar;
    charSel_e         sel;
    logic             firstData;
    logic [IDX_W-1:0] dataIdx;
  } dpCmd_t;

  function automatic logic [7:0] protectId(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] addCarry(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

endpackage

// File: rtl/linTxDatapath.sv
module linTxDatapath
  import linTxPkg::*;
#(
  parameter int OVS        = 16,
  parameter int BREAK_BITS = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baudTick,
  input  logic                   busIn,
  input  dpCmd_t                 cmd,
  input  logic [7:0]             pid,
  input  logic                   enhanced,
  input  logic [BUF_BYTES*8-1:0] bufData,
  output logic                   txOut,
  output logic                   fieldDone,
  output logic                   bitErr
);

  localparam int SH_W  = BREAK_BITS + 1;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam int PH_W  = $clog2(OVS);
  localparam int MID   = OVS / 2 - 1;
  localparam int CHAR_BITS = 10;

  logic [SH_W-1:0]  shReg;
  logic [CNT_W-1:0] bitsLeft;
  logic [PH_W-1:0]  phase;
  logic             active;
  logic [7:0]       sumAcc;
  logic [7:0]       dataByte;
  logic [7:0]       charByte;
  logic [7:0]       sumBase;

  assign dataByte = bufData[{cmd.dataIdx, 3'b000} +: 8];
  assign sumBase  = cmd.firstData ? (enhanced ? pid : 8'h00) : sumAcc;

  always_comb begin
    unique case (cmd.sel)
      SEL_SYNC: charByte = 8'h55;
      SEL_PID:  charByte = pid;
      SEL_DATA: charByte = dataByte;
      default:  charByte = ~sumAcc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '1;
      bitsLeft  <= '0;
      phase     <= '0;
      active    <= 1'b0;
      sumAcc    <= '0;
      fieldDone <= 1'b0;
      bitErr    <= 1'b0;
    end else begin
      fieldDone <= 1'b0;
      bitErr    <= 1'b0;
      if (cmd.loadBreak) begin
        shReg    <= {1'b1, {BREAK_BITS{1'b0}}};
        bitsLeft <= CNT_W'(SH_W);
        phase    <= '0;
        active   <= 1'b1;
      end else if (cmd.loadChar) begin
        shReg    <= {{(SH_W-CHAR_BITS){1'b1}}, 1'b1, charByte, 1'b0};
        bitsLeft <= CNT_W'(CHAR_BITS);
        phase    <= '0;
        active   <= 1'b1;
        if (cmd.sel == SEL_DATA) sumAcc <= addCarry(sumBase, dataByte);
      end else if (active && baudTick) begin
        if (phase == PH_W'(MID) && busIn != shReg[0]) begin
          active <= 1'b0;
          bitErr <= 1'b1;
          phase  <= '0;
        end else if (phase == PH_W'(OVS - 1)) begin
          phase    <= '0;
          shReg    <= {1'b1, shReg[SH_W-1:1]};
          bitsLeft <= bitsLeft - 1'b1;
          if (bitsLeft == CNT_W'(1)) begin
            active    <= 1'b0;
            fieldDone <= 1'b1;
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  assign txOut = active ? shReg[0] : 1'b1;

endmodule

// File: rtl/linTxCtrl.sv
module linTxCtrl
  import linTxPkg::*;
#(
  parameter int DFL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hdrReq,
  input  logic [5:0]       cfgId,
  input  logic [DFL_W-1:0] cfgDfl,
  input  logic             cfgPublish,
  input  logic             cfgEnhanced,
  input  logic             bufEmptyClr,
  input  logic             fieldDone,
  input  logic             bitErr,
  output dpCmd_t           cmd,
  output logic [7:0]       pid,
  output logic             enhanced,
  output logic             busy,
  output logic             doneFlag,
  output logic             hdrDoneFlag,
  output logic             bitErrFlag,
  output logic             bufEmptyFlag
);

  localparam int CNT_W = DFL_W + 1;

  txState_e         state, stateNxt;
  logic [DFL_W-1:0] dflQ;
  logic             publishQ;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] totalBytes;
  logic startFrame, incCnt, setDone, setHdr, setErr, setEmpty, clrEmpty;

  assign totalBytes = {1'b0, dflQ} + CNT_W'(1);

  always_comb begin
    cmd        = '0;
    stateNxt   = state;
    startFrame = 1'b0;
    incCnt     = 1'b0;
    setDone    = 1'b0;
    setHdr     = 1'b0;
    setErr     = 1'b0;
    setEmpty   = 1'b0;
    clrEmpty   = 1'b0;
    if (bitErr && state != ST_IDLE) begin
      stateNxt = ST_IDLE;
      setErr   = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (hdrReq) begin
          cmd.loadBreak = 1'b1;
          startFrame    = 1'b1;
          stateNxt      = ST_BREAK;
        end
        ST_BREAK: if (fieldDone) begin
          cmd.loadChar = 1'b1;
          cmd.sel      = SEL_SYNC;
          stateNxt     = ST_SYNC;
        end
        ST_SYNC: if (fieldDone) begin
          cmd.loadChar = 1'b1;
          cmd.sel      = SEL_PID;
          stateNxt     = ST_PID;
        end
        ST_PID: if (fieldDone) begin
          if (publishQ) begin
            cmd.loadChar  = 1'b1;
            cmd.sel       = SEL_DATA;
            cmd.firstData = 1'b1;
            incCnt        = 1'b1;
            stateNxt      = ST_DATA;
          end else begin
            setHdr   = 1'b1;
            stateNxt = ST_IDLE;
          end
        end
        ST_DATA: if (fieldDone) begin
          if (byteCnt == totalBytes) begin
            cmd.loadChar = 1'b1;
            cmd.sel      = SEL_CSUM;
            stateNxt     = ST_CSUM;
          end else if (byteCnt[IDX_W-1:0] == '0) begin
            setEmpty = 1'b1;
            stateNxt = ST_WAIT;
          end else begin
            cmd.loadChar = 1'b1;
            cmd.sel      = SEL_DATA;
            cmd.dataIdx  = byteCnt[IDX_W-1:0];
            incCnt       = 1'b1;
          end
        end
        ST_WAIT: if (bufEmptyClr) begin
          cmd.loadChar = 1'b1;
          cmd.sel      = SEL_DATA;
          cmd.dataIdx  = '0;
          incCnt       = 1'b1;
          clrEmpty     = 1'b1;
          stateNxt     = ST_DATA;
        end
        ST_CSUM: if (fieldDone) begin
          setDone  = 1'b1;
          stateNxt = ST_IDLE;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      dflQ         <= '0;
      publishQ     <= 1'b0;
      pid          <= '0;
      enhanced     <= 1'b0;
      byteCnt      <= '0;
      doneFlag     <= 1'b0;
      hdrDoneFlag  <= 1'b0;
      bitErrFlag   <= 1'b0;
      bufEmptyFlag <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startFrame) begin
        dflQ         <= cfgDfl;
        publishQ     <= cfgPublish;
        pid          <= protectId(cfgId);
        enhanced     <= cfgEnhanced;
        byteCnt      <= '0;
        doneFlag     <= 1'b0;
        hdrDoneFlag  <= 1'b0;
        bitErrFlag   <= 1'b0;
        bufEmptyFlag <= 1'b0;
      end
      if (incCnt)   byteCnt      <= byteCnt + 1'b1;
      if (setDone)  doneFlag     <= 1'b1;
      if (setHdr)   hdrDoneFlag  <= 1'b1;
      if (setErr)   bitErrFlag   <= 1'b1;
      if (setEmpty) bufEmptyFlag <= 1'b1;
      if (clrEmpty) bufEmptyFlag <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/linMasterTx.sv
module linMasterTx
  import linTxPkg::*;
#(
  parameter int OVS        = 16,
  parameter int BREAK_BITS = 13,
  parameter int DFL_W      = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   baudTick,
  input  logic                   hdrReq,
  input  logic [5:0]             cfgId,
  input  logic [DFL_W-1:0]       cfgDfl,
  input  logic                   cfgPublish,
  input  logic                   cfgEnhanced,
  input  logic [BUF_BYTES*8-1:0] bufData,
  input  logic                   bufEmptyClr,
  input  logic                   busIn,
  output logic                   txOut,
  output logic                   busy,
  output logic                   doneFlag,
  output logic                   hdrDoneFlag,
  output logic                   bitErrFlag,
  output logic                   bufEmptyFlag
);

  dpCmd_t     cmd;
  logic [7:0] pid;
  logic       enhanced;
  logic       fieldDone;
  logic       bitErr;

  linTxCtrl #(.DFL_W(DFL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hdrReq(hdrReq), .cfgId(cfgId), .cfgDfl(cfgDfl),
    .cfgPublish(cfgPublish), .cfgEnhanced(cfgEnhanced), .bufEmptyClr(bufEmptyClr),
    .fieldDone(fieldDone), .bitErr(bitErr), .cmd(cmd), .pid(pid), .enhanced(enhanced),
    .busy(busy), .doneFlag(doneFlag), .hdrDoneFlag(hdrDoneFlag),
    .bitErrFlag(bitErrFlag), .bufEmptyFlag(bufEmptyFlag)
  );

  linTxDatapath #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .busIn(busIn), .cmd(cmd),
    .pid(pid), .enhanced(enhanced), .bufData(bufData), .txOut(txOut),
    .fieldDone(fieldDone), .bitErr(bitErr)
  );

endmodule

// File: rtl/linMasterTxChk.sv
module linMasterTxChk (
  input logic clk,
  input logic rstN,
  input logic hdrReq,
  input logic txOut,
  input logic busy,
  input logic doneFlag,
  input logic hdrDoneFlag,
  input logic bitErrFlag,
  input logic bufEmptyFlag
);

  // R1
  idle_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R12
  busy_on_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hdrReq) |=> busy);

  // R8
  done_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> (!bitErrFlag && !busy));

  // R9
  header_only_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrDoneFlag) |-> (!busy && !doneFlag));

  // R10
  refill_wait_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufEmptyFlag |-> (txOut && busy));

  // R11
  bit_error_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitErrFlag) |-> (!busy && !doneFlag));

endmodule

bind linMasterTx linMasterTxChk i_chk (.*);

// File: tb/test_linMasterTx.sv
module test_linMasterTx;

  localparam int OVS   = 8;
  localparam int DFL_W = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hdrReq = 1'b0;
  logic [5:0]  cfgId = '0;
  logic [DFL_W-1:0] cfgDfl = '0;
  logic        cfgPublish = 1'b0;
  logic        cfgEnhanced = 1'b0;
  logic [63:0] bufData = '0;
  logic        bufEmptyClr = 1'b0;
  logic        forceLow = 1'b0;
  logic        busIn;
  logic        txOut, busy, doneFlag, hdrDoneFlag, bitErrFlag, bufEmptyFlag;

  int nChecks = 0;
  int nFail = 0;
  int emptyRises = 0;
  int expQ[$];
  string tagQ[$];
  logic [7:0] dataBytes [64];

  always #5 clk = ~clk;
  assign busIn = txOut & ~forceLow;

  linMasterTx #(.OVS(OVS), .DFL_W(DFL_W)) i_linMasterTx (
    .clk(clk), .rstN(rstN), .baudTick(1'b1), .hdrReq(hdrReq), .cfgId(cfgId),
    .cfgDfl(cfgDfl), .cfgPublish(cfgPublish), .cfgEnhanced(cfgEnhanced),
    .bufData(bufData), .bufEmptyClr(bufEmptyClr), .busIn(busIn), .txOut(txOut),
    .busy(busy), .doneFlag(doneFlag), .hdrDoneFlag(hdrDoneFlag),
    .bitErrFlag(bitErrFlag), .bufEmptyFlag(bufEmptyFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int refPid(input int id);
    int b[6];
    int p0, p1;
    for (int i = 0; i < 6; i++) b[i] = (id >> i) & 1;
    p0 = b[0] ^ b[1] ^ b[2] ^ b[4];
    p1 = 1 - (b[1] ^ b[3] ^ b[4] ^ b[5]);
    return id | (p0 << 6) | (p1 << 7);
  endfunction

  function automatic int refSum(input int pid, input int n, input bit enh);
    int s = enh ? pid : 0;
    for (int i = 0; i < n; i++) begin
      s = s + dataBytes[i];
      if (s > 255) s = s - 255;
    end
    return (~s) & 255;
  endfunction

  // monitor: decode characters from the bus and compare with the queue
  initial begin
    int item;
    string tag;
    int lowLen;
    logic [7:0] got;
    logic startBit, stopBit;
    forever begin
      @(negedge clk);
      if (rstN && txOut === 1'b0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R11/R12 unexpected bus activity", 0, 1);
          while (txOut === 1'b0) @(negedge clk);
        end else begin
          item = expQ.pop_front();
          tag  = tagQ.pop_front();
          if (item < 0) begin
            lowLen = 1;
            forever begin
              @(negedge clk);
              if (txOut === 1'b0) lowLen++;
              else break;
            end
            check(lowLen == 13 * OVS, "R2 break length", lowLen, 13 * OVS);
          end else begin
            repeat (OVS / 2) @(negedge clk);
            startBit = txOut;
            for (int i = 0; i < 8; i++) begin
              repeat (OVS) @(negedge clk);
              got[i] = txOut;
            end
            repeat (OVS) @(negedge clk);
            stopBit = txOut;
            check(startBit == 1'b0 && stopBit == 1'b1, "R3 character framing",
                  {startBit, stopBit}, 1);
            check(got == item[7:0], tag, got, item);
          end
        end
      end
    end
  end

  always @(negedge clk) if (rstN && $rose(bufEmptyFlag)) emptyRises++;

  task automatic loadChunk(input int c);
    for (int k = 0; k < 8; k++) bufData[8*k +: 8] = dataBytes[c*8 + k];
  endtask

  task automatic runFrame(input int id, input int nBytes, input bit pub, input bit enh);
    int pid = refPid(id);
    int startRises;
    int chunks;
    expQ.push_back(-1);        tagQ.push_back("R2 break");
    expQ.push_back(8'h55);     tagQ.push_back("R3 sync byte");
    expQ.push_back(pid);       tagQ.push_back("R4 protected id");
    if (pub) begin
      for (int i = 0; i < nBytes; i++) begin
        expQ.push_back(dataBytes[i]);
        tagQ.push_back("R5 data byte");
      end
      expQ.push_back(refSum(pid, nBytes, enh));
      tagQ.push_back(enh ? "R7 enhanced checksum" : "R6 classic checksum");
    end
    @(negedge clk);
    cfgId = 6'(id); cfgDfl = DFL_W'(nBytes - 1); cfgPublish = pub; cfgEnhanced = enh;
    loadChunk(0);
    startRises = emptyRises;
    hdrReq = 1'b1;
    @(negedge clk);
    hdrReq = 1'b0;
    check(busy == 1'b1, "R12 busy after request", busy, 1);
    chunks = pub ? (nBytes - 1) / 8 : 0;
    for (int c = 1; c <= chunks; c++) begin
      while (!bufEmptyFlag) @(negedge clk);
      repeat (2 * OVS) begin
        @(negedge clk);
        if (txOut !== 1'b1) check(1'b0, "R10 bus recessive while waiting", txOut, 1);
      end
      check(bufEmptyFlag == 1'b1 && busy == 1'b1, "R10 pause holds", bufEmptyFlag, 1);
      loadChunk(c);
      bufEmptyClr = 1'b1;
      @(negedge clk);
      bufEmptyClr = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R5 all characters sent", expQ.size(), 0);
    check(emptyRises - startRises == chunks, "R10 refill requests",
          emptyRises - startRises, chunks);
    check(doneFlag == pub, "R8 done flag", doneFlag, pub);
    check(hdrDoneFlag == !pub, "R9 header-only flag", hdrDoneFlag, !pub);
    check(bitErrFlag == 1'b0, "R11 no bit error", bitErrFlag, 0);
    check(txOut == 1'b1, "R1 idle recessive", txOut, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txOut == 1'b1 && busy == 1'b0, "R1 reset outputs", {txOut, busy}, 2);
    check({doneFlag, hdrDoneFlag, bitErrFlag, bufEmptyFlag} == 4'b0, "R1 reset flags",
          {doneFlag, hdrDoneFlag, bitErrFlag, bufEmptyFlag}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // classic, four bytes
    for (int i = 0; i < 64; i++) dataBytes[i] = 8'(i * 37 + 11);
    runFrame(6'h10, 4, 1'b1, 1'b0);
    // enhanced, exactly one full buffer (no refill)
    for (int i = 0; i < 64; i++) dataBytes[i] = 8'(8'hF0 + i * 3);
    runFrame(6'h3C, 8, 1'b1, 1'b1);
    // subscriber, header only (R9)
    runFrame(6'h3F, 1, 1'b0, 1'b0);
    // single byte, enhanced, id 0
    dataBytes[0] = 8'hFF;
    runFrame(6'h00, 1, 1'b1, 1'b1);
    // extended response, two refills (R10)
    for (int i = 0; i < 64; i++) dataBytes[i] = 8'(255 - i * 7);
    runFrame(6'h2A, 20, 1'b1, 1'b0);

    // R12: request while busy is ignored, config changes not taken
    fork
      runFrame(6'h15, 3, 1'b1, 1'b1);
      begin
        repeat (30 * OVS) @(negedge clk);
        cfgId = 6'h01; cfgDfl = DFL_W'(9); cfgPublish = 1'b0;
        hdrReq = 1'b1;
        @(negedge clk);
        hdrReq = 1'b0;
        check(busy == 1'b1, "R12 busy held through ignored request", busy, 1);
      end
    join

    // R11: force the break delimiter low
    expQ.push_back(-1); tagQ.push_back("R2 break");
    @(negedge clk);
    cfgId = 6'h22; cfgDfl = DFL_W'(2); cfgPublish = 1'b1; cfgEnhanced = 1'b0;
    hdrReq = 1'b1;
    @(negedge clk);
    hdrReq = 1'b0;
    while (txOut !== 1'b0) @(negedge clk);
    while (txOut !== 1'b1) @(negedge clk);
    forceLow = 1'b1;
    repeat (OVS) @(negedge clk);
    forceLow = 1'b0;
    while (busy) @(negedge clk);
    check(bitErrFlag == 1'b1, "R11 bit error flag", bitErrFlag, 1);
    check(doneFlag == 1'b0, "R11 done stays clear", doneFlag, 0);
    repeat (30 * OVS) @(negedge clk);
    check(expQ.size() == 0 && txOut == 1'b1, "R11 frame aborted", expQ.size(), 0);

    // R8: next frame clears the error and completes
    for (int i = 0; i < 64; i++) dataBytes[i] = 8'(i + 1);
    runFrame(6'h07, 2, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule